// File: doc/BRIEF.md
# Two-Table Negative Exponential Evaluator

This block turns a non-negative fixed-point argument `a` into a 32-bit unsigned approximation of e^(-a). The argument is 44 bits wide with 24 fraction bits. A result of 1.0 is encoded as all ones. The block sits in a classifier datapath. An upstream multiplier supplies the argument together with a flag that marks the product as exactly zero. A last-of-group marker travels with each sample so that a downstream accumulator knows where a group ends.

The block does not use one table indexed by the whole argument. It writes the argument as `b + c` and uses e^-(b+c) = e^-b · e^-c. The high part `b` addresses one table and the low part `c` addresses a second table. The two 32-bit entries are multiplied, and the upper half of the product is kept. There are two shortcuts around the tables. An argument of 24.0 or more gives 0, and an asserted zero flag gives 1.0. A host fills both tables through two independent write ports before any lookups are issued. The block is a three-stage pipeline that accepts one sample per cycle.

The lookup window is parameterised by `HI_W` and `LO_W`. It always ends at argument bit 28 and spans `HI_W+LO_W` bits, so it covers bits 28 down to `29-HI_W-LO_W`. With `HI_W = LO_W = 14` the window is bits 28..1 and only bit 0 is dropped. The defaults are `HI_W = LO_W = 10`, which keeps each table at 1024 entries.

Top module: `nexp_split_unit`

## Requirements
- R1: While `rst_n` is low and right after it is released, `out_valid`, `out_last` and `out_value` are all 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, three rising edges later. `out_valid` is never high at any other time.
- R3: `out_last` equals the `in_last` value of the sample reported in the same cycle, and is 0 when `out_valid` is low.
- R4: When `in_zero` is 0 and the argument is 24.0 or more (any of bits 43..29 set, or bits 28 and 27 both set), the reported value is 32'h00000000. The value 24.0 minus one LSB is not forced to zero.
- R5: When `in_zero` is 1, the reported value is 32'hFFFFFFFF whatever the argument, including arguments that would saturate under R4.
- R6: Argument bits below the window (bits `28-HI_W-LO_W` down to 0) have no effect on the reported value.
- R7: Otherwise, the window `arg[28 -: HI_W+LO_W]` is split as follows. Its upper `HI_W` bits address the high table and its lower `LO_W` bits address the low table. The reported value is bits 63..32 of the 64-bit unsigned product of the two entries.
- R8: A cycle with `hi_we` (or `lo_we`) high stores `hi_wdata` at `hi_waddr` (or `lo_wdata` at `lo_waddr`). Later lookups return the most recently written entry.
- R9: While `out_valid` is low, `out_value` keeps the last reported value.
- R10: Samples presented on consecutive cycles are all reported, in order, on consecutive cycles, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_we | input | 1 | Write enable for the high-part table |
| hi_waddr | input | HI_W | High-part table write address |
| hi_wdata | input | 32 | High-part table write data |
| lo_we | input | 1 | Write enable for the low-part table |
| lo_waddr | input | LO_W | Low-part table write address |
| lo_wdata | input | 32 | Low-part table write data |
| in_valid | input | 1 | Sample present on the argument inputs |
| in_arg | input | 44 | Argument, unsigned, 24 fraction bits |
| in_zero | input | 1 | Argument is exactly zero; result is 1.0 |
| in_last | input | 1 | Sample is the last of its group |
| out_valid | output | 1 | Result present |
| out_value | output | 32 | e^(-a) as an unsigned fraction, all ones for 1.0 |
| out_last | output | 1 | Last-of-group marker aligned with the result |

## Verification
The shortcut flags and the table data travel in separate registers. If the stage holding the saturate or one flag slips against its data, an otherwise valid table product shows up at the ports as 0 or all ones. This appears exactly three cycles after the offending sample and is caught by the per-sample comparison. A wrong split of the window or a wrong half of the product corrupts every table-path result immediately. Table entries set to all ones make a dropped high product bit visible. A valid or last register that is missing, doubled or not reset shows up as an unexpected or missing `out_valid` cycle, or as a misplaced `out_last`, on the first sample after reset.

// File: rtl/nexp_pkg.sv
package nexp_pkg;

  localparam int ARG_W   = 44;
  localparam int FRAC_W  = 24;
  // top argument bit that can feed a table: 2^4 = 16 in the integer part
  localparam int WIN_TOP = FRAC_W + 4;

  // control bits that ride beside the data through the pipeline
  typedef struct packed {
    logic valid;
    logic last;
    logic one;
    logic sat;
  } nexp_tag_t;

  // argument >= 24.0: anything at or above 32, or 16 and 8 together
  function automatic logic f_saturates(input logic [ARG_W-1:0] a);
    return (|a[ARG_W-1:WIN_TOP+1]) | (a[WIN_TOP] & a[WIN_TOP-1]);
  endfunction

  function automatic nexp_tag_t f_make_tag(input logic valid, input logic last,
                                           input logic zero, input logic sat);
    nexp_tag_t t;
    t.valid = valid;
    t.last  = valid & last;
    t.one   = valid & zero;
    t.sat   = valid & sat;
    return t;
  endfunction

  // upper half of an unsigned product of two equal-width words
  function automatic logic [31:0] f_mul_hi32(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    return full[63:32];
  endfunction

endpackage

// File: rtl/nexp_arg_split.sv
module nexp_arg_split
  import nexp_pkg::*;
#(
  parameter int HI_W = 10,
  parameter int LO_W = 10
) (
  input  logic [ARG_W-1:0] arg,
  output logic [HI_W-1:0]  hi_addr,
  output logic [LO_W-1:0]  lo_addr,
  output logic             sat
);

  localparam int WIN_W = HI_W + LO_W;

  logic [WIN_W-1:0] window;

  assign window  = arg[WIN_TOP -: WIN_W];
  assign hi_addr = window[WIN_W-1 -: HI_W];
  assign lo_addr = window[LO_W-1:0];
  assign sat     = f_saturates(arg);

endmodule

// File: rtl/nexp_lut.sv
module nexp_lut #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nexp_mul_hi.sv
module nexp_mul_hi
  import nexp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nexp_tag_t     in_tag,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output nexp_tag_t     out_tag,
  output logic [DW-1:0] out_hi
);

  localparam int PW = 2 * DW;

  logic [PW-1:0] product;

  generate
    if (DW == 32) begin : g_w32
      assign product = {f_mul_hi32(a, b), {DW{1'b0}}};
    end else begin : g_wn
      assign product = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_tag <= '0;
      out_hi  <= '0;
    end else begin
      out_tag <= in_tag;
      out_hi  <= product[PW-1 -: DW];
    end
  end

endmodule

// File: rtl/nexp_out_sel.sv
module nexp_out_sel
  import nexp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nexp_tag_t     in_tag,
  input  logic [DW-1:0] tab_val,
  output logic          sel_one,
  output logic          sel_sat,
  output logic          sel_tab,
  output logic          out_valid,
  output logic          out_last,
  output logic [DW-1:0] out_value
);

  logic [DW-1:0] next_value;

  // zero-flag shortcut outranks saturation
  assign sel_one = in_tag.valid & in_tag.one;
  assign sel_sat = in_tag.valid & in_tag.sat & ~in_tag.one;
  assign sel_tab = in_tag.valid & ~in_tag.sat & ~in_tag.one;

  always_comb begin
    next_value = out_value;
    if (sel_one)      next_value = '1;
    else if (sel_sat) next_value = '0;
    else if (sel_tab) next_value = tab_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_tag.valid;
      out_last  <= in_tag.last;
      out_value <= next_value;
    end
  end

endmodule

// File: rtl/nexp_split_unit.sv
module nexp_split_unit
  import nexp_pkg::*;
#(
  parameter int HI_W  = 10,
  parameter int LO_W  = 10,
  parameter int OUT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hi_we,
  input  logic [HI_W-1:0]      hi_waddr,
  input  logic [OUT_W-1:0]     hi_wdata,
  input  logic                 lo_we,
  input  logic [LO_W-1:0]      lo_waddr,
  input  logic [OUT_W-1:0]     lo_wdata,
  input  logic                 in_valid,
  input  logic [ARG_W-1:0]     in_arg,
  input  logic                 in_zero,
  input  logic                 in_last,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_value,
  output logic                 out_last
);

  // named internal events, also observed by the bound checker
  logic [HI_W-1:0]  w_hi_addr;
  logic [LO_W-1:0]  w_lo_addr;
  logic             w_det_sat;
  nexp_tag_t        w_tag0;
  nexp_tag_t        r_tag1;
  nexp_tag_t        w_tag2;
  logic [OUT_W-1:0] w_hi_ent;
  logic [OUT_W-1:0] w_lo_ent;
  logic [OUT_W-1:0] w_prod_hi;
  logic             w_sel_one;
  logic             w_sel_sat;
  logic             w_sel_tab;

  nexp_arg_split #(.HI_W(HI_W), .LO_W(LO_W)) u_split (
    .arg     (in_arg),
    .hi_addr (w_hi_addr),
    .lo_addr (w_lo_addr),
    .sat     (w_det_sat)
  );

  assign w_tag0 = f_make_tag(in_valid, in_last, in_zero, w_det_sat);

  // stage 1: table reads and tag capture
  nexp_lut #(.AW(HI_W), .DW(OUT_W)) u_hi_lut (
    .clk   (clk),
    .we    (hi_we),
    .waddr (hi_waddr),
    .wdata (hi_wdata),
    .raddr (w_hi_addr),
    .rdata (w_hi_ent)
  );

  nexp_lut #(.AW(LO_W), .DW(OUT_W)) u_lo_lut (
    .clk   (clk),
    .we    (lo_we),
    .waddr (lo_waddr),
    .wdata (lo_wdata),
    .raddr (w_lo_addr),
    .rdata (w_lo_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_tag1 <= '0;
    else        r_tag1 <= w_tag0;
  end

  // stage 2: product, upper half kept
  nexp_mul_hi #(.DW(OUT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_tag  (r_tag1),
    .a       (w_hi_ent),
    .b       (w_lo_ent),
    .out_tag (w_tag2),
    .out_hi  (w_prod_hi)
  );

  // stage 3: shortcut selection and output register
  nexp_out_sel #(.DW(OUT_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tag    (w_tag2),
    .tab_val   (w_prod_hi),
    .sel_one   (w_sel_one),
    .sel_sat   (w_sel_sat),
    .sel_tab   (w_sel_tab),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_value (out_value)
  );

endmodule

// File: rtl/nexp_split_unit_chk.sv
module nexp_split_unit_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_zero,
  input logic             in_last,
  input logic             det_sat,
  input logic             sel_one,
  input logic             sel_sat,
  input logic             sel_tab,
  input logic             out_valid,
  input logic             out_last,
  input logic [OUT_W-1:0] out_value
);

  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R2 / R10: one result per sample, three edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3: group marker follows its sample
  p_last_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> (out_last == $past(in_last, 3)));

  // R4: saturating argument reports zero
  p_sat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && $past(in_valid && det_sat && !in_zero, 3))
      |-> (out_value == '0));

  // R5: zero flag reports 1.0
  p_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && $past(in_valid && in_zero, 3))
      |-> (out_value == '1));

  // R9: output held between results
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !out_valid) |-> $stable(out_value));

  // R3: marker never shown without a result
  p_last_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_last);

  // R4 / R5: at most one result source picked per cycle
  always_comb begin
    if (rst_n) begin
      a_sel_onehot_r4: assert ($onehot0({sel_one, sel_sat, sel_tab}));
    end
  end

endmodule

bind nexp_split_unit nexp_split_unit_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_zero   (in_zero),
  .in_last   (in_last),
  .det_sat   (w_det_sat),
  .sel_one   (w_sel_one),
  .sel_sat   (w_sel_sat),
  .sel_tab   (w_sel_tab),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_value (out_value)
);

// File: tb/nexp_split_unit_tb.sv
`timescale 1ns/1ps
module nexp_split_unit_tb;

  localparam int HI_W  = 10;
  localparam int LO_W  = 10;
  localparam int DW    = 32;
  localparam int AW    = 44;
  localparam int DROP  = 29 - HI_W - LO_W;   // lowest window bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_we = 1'b0, lo_we = 1'b0;
  logic [HI_W-1:0] hi_waddr = '0;
  logic [LO_W-1:0] lo_waddr = '0;
  logic [DW-1:0]   hi_wdata = '0, lo_wdata = '0;
  logic            in_valid = 1'b0, in_zero = 1'b0, in_last = 1'b0;
  logic [AW-1:0]   in_arg = '0;
  logic            out_valid, out_last;
  logic [DW-1:0]   out_value;

  always #2.5 clk = ~clk;

  nexp_split_unit #(.HI_W(HI_W), .LO_W(LO_W), .OUT_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hi_we(hi_we), .hi_waddr(hi_waddr), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_waddr(lo_waddr), .lo_wdata(lo_wdata),
    .in_valid(in_valid), .in_arg(in_arg), .in_zero(in_zero), .in_last(in_last),
    .out_valid(out_valid), .out_value(out_value), .out_last(out_last)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] hi_tab [1 << HI_W];
  logic [DW-1:0] lo_tab [1 << LO_W];

  logic [DW-1:0] q_val [$];
  logic          q_last [$];
  int            q_cyc [$];
  string         q_req [$];
  logic [DW-1:0] last_seen = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a, input logic z);
    logic [63:0] win, p;
    int h, l;
    if (z) return {DW{1'b1}};
    if (a >= (44'd24 << 24)) return '0;
    win = ({20'd0, a} >> DROP) & ((64'd1 << (HI_W + LO_W)) - 1);
    h = int'(win >> LO_W);
    l = int'(win % (64'd1 << LO_W));
    p = {32'd0, hi_tab[h]} * {32'd0, lo_tab[l]};
    return p[63:32];
  endfunction

  function automatic string req_of(input logic [AW-1:0] a, input logic z);
    if (z) return "R5";
    if (a >= (44'd24 << 24)) return "R4";
    return "R7";
  endfunction

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic z,
                       input logic lst, input string req);
    @(negedge clk);
    in_valid = v; in_arg = a; in_zero = z; in_last = lst;
    if (v) begin
      q_val.push_back(model(a, z));
      q_last.push_back(lst);
      q_cyc.push_back(cyc + 3);
      q_req.push_back(req == "" ? req_of(a, z) : req);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, "");
  endtask

  task automatic write_both(input int addr, input logic [DW-1:0] hv, input logic [DW-1:0] lv);
    @(negedge clk);
    hi_we = 1'b1; hi_waddr = HI_W'(addr); hi_wdata = hv;
    lo_we = 1'b1; lo_waddr = LO_W'(addr); lo_wdata = lv;
    hi_tab[addr] = hv; lo_tab[addr] = lv;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 64'd1, 64'd0);
        end else begin
          logic [DW-1:0] ev;
          logic el;
          int ec;
          string er;
          ev = q_val.pop_front(); el = q_last.pop_front();
          ec = q_cyc.pop_front(); er = q_req.pop_front();
          check(cyc == ec, "R10", "result cycle", 64'(cyc), 64'(ec));
          check(out_value == ev, er, "out_value", 64'(out_value), 64'(ev));
          check(out_last == el, "R3", "out_last", 64'(out_last), 64'(el));
          last_seen = out_value;
        end
      end else begin
        if (out_value != last_seen || out_last)
          check(1'b0, "R9", "held output", 64'(out_value), 64'(last_seen));
      end
    end
  end

  initial begin
    int seed;
    logic [AW-1:0] a;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_value == '0 && out_last == 1'b0, "R1",
          "reset state", {out_valid, out_last, out_value}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_value == '0 && out_last == 1'b0, "R1",
          "after release", {out_valid, out_last, out_value}, 64'd0);

    // R8: fill both tables; entry 0 all ones to expose the product's top bit
    for (int i = 0; i < (1 << HI_W); i++) begin
      logic [DW-1:0] hv, lv;
      hv = (i == 0) ? 32'hFFFF_FFFF : $urandom;
      lv = (i == 0) ? 32'hFFFF_FFFF : $urandom;
      @(negedge clk);
      hi_we = 1'b1; hi_waddr = HI_W'(i); hi_wdata = hv; hi_tab[i] = hv;
      lo_we = 1'b1; lo_waddr = LO_W'(i); lo_wdata = lv; lo_tab[i] = lv;
    end
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
    idle(2);

    // directed corners
    drive(1'b1, 44'd0, 1'b0, 1'b0, "R7");                       // FFFFFFFE
    drive(1'b1, 44'd0, 1'b1, 1'b1, "R5");
    drive(1'b1, 44'd1 << 43, 1'b1, 1'b0, "R5");                 // priority over R4
    drive(1'b1, 44'd24 << 24, 1'b0, 1'b0, "R4");
    drive(1'b1, (44'd24 << 24) - 44'd1, 1'b0, 1'b1, "R4");      // just below
    drive(1'b1, 44'd1 << 29, 1'b0, 1'b0, "R4");
    drive(1'b1, 44'd1 << 43, 1'b0, 1'b0, "R4");
    drive(1'b1, (44'd1 << 28) | (44'd1 << 26), 1'b0, 1'b0, "R4"); // 20.0 not saturated
    drive(1'b1, 44'h000_0ABC_D000, 1'b0, 1'b0, "R6");
    drive(1'b1, 44'h000_0ABC_D000 | ((44'd1 << DROP) - 44'd1), 1'b0, 1'b0, "R6");
    idle(5);

    // R8: overwrite an entry and look it up again
    write_both(3, 32'h8000_0000, 32'h8000_0000);
    idle(1);
    a = (44'd3 << (DROP + LO_W)) | (44'd3 << DROP);
    drive(1'b1, a, 1'b0, 1'b0, "R8");                           // 40000000
    idle(5);

    // R10: back-to-back burst, then constrained random traffic
    for (int i = 0; i < 40; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      drive(1'b1, r[43:0] % (44'd24 << 24), 1'b0, r[63], "R10");
    end
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] r;
      logic v, z, l;
      r = {$urandom, $urandom};
      case ($urandom % 4)
        0: a = r[43:0];
        1: a = r[43:0] % (44'd24 << 24);
        2: a = (44'd24 << 24) - 44'd4 + AW'(r[2:0]);
        default: a = AW'(r[27:0]);
      endcase
      v = ($urandom % 4) != 0;
      z = ($urandom % 10) == 0;
      l = ($urandom % 2) == 1;
      drive(v, a, z, l, "");
    end
    idle(6);
    check(q_val.size() == 0, "R2", "results outstanding", 64'(q_val.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule